// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block holds the control state of a single warp of 32 lanes that execute in lockstep behind one shared program counter. It keeps the warp's next fetch address and an active-lane mask, and it serialises the two sides of a conditional branch on which lanes disagree. It runs the taken side first with only the taken lanes enabled. It then runs the fall-through side with the remaining lanes. At the reconvergence address it restores the mask that was live before the branch.

Each issue cycle carries the address of the instruction being issued and, optionally, a branch event. A branch event holds a per-lane taken vector, a target address and a reconvergence address. Divergence is recorded on a bounded LIFO of entries. Each entry holds a trigger address, a resume address and a mask. Nested divergence unwinds in reverse order. Other warps have their own instance and are unaffected.

Top module: `warp_reconv_stack`

## Requirements
- R1: While reset is low, and after it is released, next_pc_o is 0, active_mask_o is all ones (0xFFFFFFFF), overflow_o is 0 and the stack is empty.
- R2: In a cycle with issue_i low, every other input is ignored. next_pc_o, active_mask_o and the stack hold their values.
- R3: An issued cycle with no branch and no reconvergence hit sets next_pc_o to fetch_pc_i + 4 and leaves the mask unchanged.
- R4: For an issued branch, the effective taken set is br_taken_i AND the active mask. If that set is zero, next_pc_o is fetch_pc_i + 4. If it equals the active mask, next_pc_o is br_target_i. In both cases the mask is unchanged and nothing is pushed.
- R5: When the effective taken set is neither zero nor the whole active mask, next_pc_o becomes br_target_i and the mask becomes the effective taken set. Two entries are pushed. The lower entry is (trigger = reconv, resume = reconv, mask = old mask). The upper entry, on top, is (trigger = reconv, resume = fetch_pc_i + 4, mask = old mask AND NOT br_taken_i).
- R6: An issued cycle whose fetch_pc_i equals the top entry's trigger, with the stack not empty, pops that entry. next_pc_o and the mask take the entry's resume address and mask. A branch event in that cycle is ignored.
- R7: The second pop at the same reconvergence address returns next_pc_o = reconv and restores the mask that was active before the branch.
- R8: Nested divergence up to DEPTH/2 levels (4 at default DEPTH 8) is kept and unwound in LIFO order. The stack never holds more than DEPTH entries.
- R9: A divergent branch that finds fewer than 2 free entries sets overflow_o and pushes nothing. The warp still moves to br_target_i under the effective taken mask. overflow_o stays high until reset.
- R10: active_mask_o is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction of this warp issues this cycle |
| fetch_pc_i | input | 32 | Address of the issuing instruction |
| br_valid_i | input | 1 | Issuing instruction is a conditional branch |
| br_taken_i | input | 32 | Per-lane branch outcome, 1 = taken |
| br_target_i | input | 32 | Branch target address |
| br_reconv_i | input | 32 | Reconvergence address of the branch |
| next_pc_o | output | 32 | Address the warp fetches next |
| active_mask_o | output | 32 | Lanes enabled for the next instruction |
| overflow_o | output | 1 | Sticky divergence-stack overflow |

## Verification
The bench targets several corner cases:
- Taken bits that fall only on lanes already disabled. A design that did not mask them first would split the warp and push entries for a branch that is really uniform.
- A reconvergence hit that coincides with a branch event. A design that let the branch win would never unwind, and the fall-through lanes would be lost.
- Four nested levels, which fill the stack exactly, followed by a fifth split. This exposes an off-by-one in the free-space test, which would either corrupt the bottom entry or raise overflow one level early.
- Overflow that persists until a second reset, and idle cycles carrying branch traffic. These catch a design that clears the flag or reacts to input that is not issued.

// File: rtl/wr_types_pkg.sv
package wr_types_pkg;
  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_FALL  = 2'd1,
    BR_JUMP  = 2'd2,
    BR_SPLIT = 2'd3
  } br_kind_e;
endpackage

// File: rtl/wr_branch_classify.sv
module wr_branch_classify
  import wr_types_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             valid_i,
  input  logic [LANES-1:0] taken_i,
  input  logic [LANES-1:0] mask_i,
  output br_kind_e         kind_o,
  output logic [LANES-1:0] taken_eff_o,
  output logic [LANES-1:0] not_taken_o
);
  assign taken_eff_o = taken_i & mask_i;
  assign not_taken_o = mask_i & ~taken_i;

  always_comb begin
    if (!valid_i)                 kind_o = BR_NONE;
    else if (taken_eff_o == '0)   kind_o = BR_FALL;
    else if (taken_eff_o == mask_i) kind_o = BR_JUMP;
    else                          kind_o = BR_SPLIT;
  end
endmodule

// File: rtl/wr_mask_stack.sv
module wr_mask_stack #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  parameter int LANES = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_pair_i,
  input  logic             pop_i,
  input  logic [PC_W-1:0]  trig_i,
  input  logic [PC_W-1:0]  lo_resume_i,
  input  logic [LANES-1:0] lo_mask_i,
  input  logic [PC_W-1:0]  hi_resume_i,
  input  logic [LANES-1:0] hi_mask_i,
  output logic             top_valid_o,
  output logic [PC_W-1:0]  top_trig_o,
  output logic [PC_W-1:0]  top_resume_o,
  output logic [LANES-1:0] top_mask_o,
  output logic             room2_o,
  output logic [CW-1:0]    count_o
);
  logic [CW-1:0] cnt_q;
  logic [DEPTH-1:0][PC_W-1:0]  trig_all;
  logic [DEPTH-1:0][PC_W-1:0]  resume_all;
  logic [DEPTH-1:0][LANES-1:0] mask_all;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [PC_W-1:0]  trig_q, resume_q;
    logic [LANES-1:0] mask_q;
    logic wr_lo, wr_hi;
    assign wr_lo = push_pair_i && (cnt_q == CW'(i));
    assign wr_hi = push_pair_i && (cnt_q + CW'(1) == CW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        trig_q   <= '0;
        resume_q <= '0;
        mask_q   <= '0;
      end else if (wr_lo) begin
        trig_q   <= trig_i;
        resume_q <= lo_resume_i;
        mask_q   <= lo_mask_i;
      end else if (wr_hi) begin
        trig_q   <= trig_i;
        resume_q <= hi_resume_i;
        mask_q   <= hi_mask_i;
      end
    end
    assign trig_all[i]   = trig_q;
    assign resume_all[i] = resume_q;
    assign mask_all[i]   = mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (push_pair_i) cnt_q <= cnt_q + CW'(2);
    else if (pop_i)       cnt_q <= cnt_q - CW'(1);
  end

  logic [IW-1:0] top_idx;
  assign top_idx      = IW'(cnt_q - CW'(1));
  assign top_valid_o  = (cnt_q != '0);
  assign top_trig_o   = trig_all[top_idx];
  assign top_resume_o = resume_all[top_idx];
  assign top_mask_o   = mask_all[top_idx];
  assign room2_o      = (cnt_q + CW'(2) <= CW'(DEPTH));
  assign count_o      = cnt_q;
endmodule

// File: rtl/warp_reconv_stack.sv
module warp_reconv_stack
  import wr_types_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int PC_W       = 32,
  parameter int DEPTH      = 8,
  parameter int INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic             br_valid_i,
  input  logic [LANES-1:0] br_taken_i,
  input  logic [PC_W-1:0]  br_target_i,
  input  logic [PC_W-1:0]  br_reconv_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [LANES-1:0] active_mask_o,
  output logic             overflow_o
);
  logic [PC_W-1:0]  pc_q;
  logic [LANES-1:0] mask_q;
  logic             ovf_q;

  br_kind_e         kind;
  logic [LANES-1:0] taken_eff, not_taken;
  logic             top_valid, room2, pop_hit, split, push_pair;
  logic [PC_W-1:0]  top_trig, top_resume, fall_pc;
  logic [LANES-1:0] top_mask;
  logic [CW-1:0]    stk_count;

  wr_branch_classify #(.LANES(LANES)) u_cls (
    .valid_i     (br_valid_i),
    .taken_i     (br_taken_i),
    .mask_i      (mask_q),
    .kind_o      (kind),
    .taken_eff_o (taken_eff),
    .not_taken_o (not_taken)
  );

  assign fall_pc   = fetch_pc_i + PC_W'(INSN_BYTES);
  assign pop_hit   = issue_i && top_valid && (fetch_pc_i == top_trig);
  assign split     = issue_i && !pop_hit && (kind == BR_SPLIT);
  assign push_pair = split && room2;

  wr_mask_stack #(.DEPTH(DEPTH), .PC_W(PC_W), .LANES(LANES)) u_stk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_pair_i  (push_pair),
    .pop_i        (pop_hit),
    .trig_i       (br_reconv_i),
    .lo_resume_i  (br_reconv_i),
    .lo_mask_i    (mask_q),
    .hi_resume_i  (fall_pc),
    .hi_mask_i    (not_taken),
    .top_valid_o  (top_valid),
    .top_trig_o   (top_trig),
    .top_resume_o (top_resume),
    .top_mask_o   (top_mask),
    .room2_o      (room2),
    .count_o      (stk_count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else if (issue_i) begin
      if (pop_hit) begin
        pc_q   <= top_resume;
        mask_q <= top_mask;
      end else begin
        unique case (kind)
          BR_JUMP:  pc_q <= br_target_i;
          BR_SPLIT: begin
            pc_q   <= br_target_i;
            mask_q <= taken_eff;
          end
          default:  pc_q <= fall_pc;
        endcase
      end
      if (split && !room2) ovf_q <= 1'b1;
    end
  end

  assign next_pc_o     = pc_q;
  assign active_mask_o = mask_q;
  assign overflow_o    = ovf_q;
endmodule

// File: rtl/wr_reconv_checker.sv
module wr_reconv_checker #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic             br_valid_i,
  input logic [LANES-1:0] br_taken_i,
  input logic [PC_W-1:0]  br_target_i,
  input logic [PC_W-1:0]  next_pc_o,
  input logic [LANES-1:0] active_mask_o,
  input logic             overflow_o,
  input logic             pop_hit,
  input logic [CW-1:0]    stk_count
);
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(next_pc_o) && $stable(active_mask_o));

  a_r5_split_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !pop_hit && br_valid_i && ((br_taken_i & active_mask_o) != '0)
      && ((br_taken_i & active_mask_o) != active_mask_o)
    |=> active_mask_o == $past(br_taken_i & active_mask_o) && next_pc_o == $past(br_target_i));

  a_r6_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && pop_hit |=> stk_count == $past(stk_count) - CW'(1));

  a_r8_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_count <= CW'(DEPTH));

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r10_mask_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_mask_o != '0);
endmodule

bind warp_reconv_stack wr_reconv_checker #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_i       (issue_i),
  .br_valid_i    (br_valid_i),
  .br_taken_i    (br_taken_i),
  .br_target_i   (br_target_i),
  .next_pc_o     (next_pc_o),
  .active_mask_o (active_mask_o),
  .overflow_o    (overflow_o),
  .pop_hit       (pop_hit),
  .stk_count     (stk_count)
);

// File: tb/sim_warp_reconv_stack.sv
module sim_warp_reconv_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        issue = 1'b0, br_valid = 1'b0;
  logic [31:0] fetch_pc = '0, br_taken = '0, br_target = '0, br_reconv = '0;
  logic [31:0] next_pc, act_mask;
  logic        ovf;

  int checks = 0, errors = 0;
  string cur_req = "R1", m_req = "R1";

  // reference model state
  logic [31:0] m_pc = '0, m_mask = '1;
  logic        m_ovf = 1'b0;
  logic [31:0] q_trig[$], q_res[$], q_mask[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_reconv_stack #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .fetch_pc_i(fetch_pc),
    .br_valid_i(br_valid), .br_taken_i(br_taken), .br_target_i(br_target),
    .br_reconv_i(br_reconv), .next_pc_o(next_pc), .active_mask_o(act_mask),
    .overflow_o(ovf)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = '0; m_mask = '1; m_ovf = 1'b0;
      q_trig.delete(); q_res.delete(); q_mask.delete();
      m_req = "R1";
    end else begin
      m_req = cur_req;
      if (issue) begin
        if (q_trig.size() > 0 && fetch_pc == q_trig[q_trig.size()-1]) begin
          m_pc = q_res.pop_back(); m_mask = q_mask.pop_back();
          void'(q_trig.pop_back());
        end else if (br_valid) begin
          logic [31:0] e;
          e = br_taken & m_mask;
          if (e == 0) m_pc = fetch_pc + 4;
          else if (e == m_mask) m_pc = br_target;
          else begin
            if (q_trig.size() <= DEPTH - 2) begin
              q_trig.push_back(br_reconv); q_res.push_back(br_reconv); q_mask.push_back(m_mask);
              q_trig.push_back(br_reconv); q_res.push_back(fetch_pc + 4);
              q_mask.push_back(m_mask & ~br_taken);
            end else m_ovf = 1'b1;
            m_pc = br_target; m_mask = e;
          end
        end else m_pc = fetch_pc + 4;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(m_req, "next_pc", next_pc, m_pc);
    chk(m_req, "mask", act_mask, m_mask);
    chk(m_req, "overflow", {31'd0, ovf}, {31'd0, m_ovf});
    chk("R10", "mask_nonzero", {31'd0, act_mask != 0}, 32'd1);
  end

  task automatic drv(bit iss, bit br, logic [31:0] tk, logic [31:0] tg, logic [31:0] rc,
                     logic [31:0] fpc, string req);
    @(posedge clk); #2;
    issue = iss; br_valid = br; br_taken = tk; br_target = tg; br_reconv = rc;
    fetch_pc = fpc; cur_req = req;
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) drv(1, 0, '0, '0, '0, m_pc, req);
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst_n = 1'b0; issue = 0; br_valid = 0;
    #(CLK_PERIOD*2);
    chk("R1", "rst_pc", next_pc, 32'h0);
    chk("R1", "rst_mask", act_mask, 32'hFFFF_FFFF);
    chk("R1", "rst_ovf", {31'd0, ovf}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    run(3, "R3");
    // R2: idle cycles with branch traffic
    drv(0, 1, 32'h0000_00F0, 32'h900, 32'h980, 32'h8, "R2");
    drv(0, 0, '0, '0, '0, 32'h44, "R2");
    // R4: uniform taken and uniform not taken
    drv(1, 1, 32'hFFFF_FFFF, 32'h100, 32'h200, m_pc, "R4");
    drv(1, 1, 32'h0, 32'h180, 32'h200, m_pc, "R4");
    // R5: split
    drv(1, 1, 32'h0000_FFFF, 32'h300, 32'h400, m_pc, "R5");
    run(1, "R5");
    // R4: taken bits only on disabled lanes
    drv(1, 1, 32'hFFFF_0000, 32'h700, 32'h800, m_pc, "R4");
    drv(1, 1, 32'hFFFF_FFFF, 32'h340, 32'h800, m_pc, "R4");
    // R6: reconvergence hit with a split branch present, branch ignored
    drv(1, 1, 32'h0000_0001, 32'h500, 32'h600, 32'h400, "R6");
    run(2, "R6");
    // R7: second pop restores full mask at reconv
    drv(1, 0, '0, '0, '0, 32'h400, "R7");
    run(2, "R3");
    // R8/R9: four nested levels fill the stack, fifth overflows
    begin
      logic [31:0] tks[4] = '{32'h0000_FFFF, 32'h0000_00FF, 32'h0000_000F, 32'h0000_0003};
      for (int k = 0; k < 4; k++) begin
        drv(1, 1, tks[k], 32'h100 * (k + 10), 32'h1000 * (k + 1), m_pc, "R8");
        run(1, "R8");
      end
      drv(1, 1, 32'h0000_0001, 32'h5000, 32'h9000, m_pc, "R9");
      run(2, "R9");
      drv(0, 0, '0, '0, '0, 32'h0, "R9");
      for (int k = 3; k >= 0; k--) begin
        drv(1, 0, '0, '0, '0, 32'h1000 * (k + 1), "R8");
        run(1, "R8");
        drv(1, 0, '0, '0, '0, 32'h1000 * (k + 1), "R8");
      end
      run(2, "R9");
    end
    chk("R9", "ovf_sticky", {31'd0, ovf}, 32'd1);
    do_reset();
    run(2, "R1");
    chk("R1", "ovf_cleared", {31'd0, ovf}, 32'd0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule